// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a periodic down-counter with a small word-addressed register interface, meant to give a processor a regular time base. Software writes a reload value, picks a count source and enables counting. Each active tick lowers the count by one. When a decrement reaches zero, the block sets a sticky expiry flag and, if allowed, raises a one-cycle interrupt pulse. On the next active tick the counter loads the reload value again.

The count source is either every cycle of the block's own clock or a single-cycle reference-tick enable that is synchronous to that clock. A configuration input says whether a reference source exists at all. A read-only calibration word reports the number of reference ticks in 10 ms, which is set by parameters. Register accesses are single-cycle requests and receive a registered response one cycle later. Requests marked unprivileged are refused with an error.

Top module: `periodic_tick_timer`

## Requirements
- R1: Word offsets decode as follows: 0x0 status/control, 0x4 reload, 0x8 current count, 0xC calibration. Any other offset, including one with address bits 1:0 not zero, reads as 0, and a write to it changes no register.
- R2: The status/control word has run-enable in bit 0, interrupt-enable in bit 1, source-select in bit 2 (1 = every clock cycle, 0 = reference tick) and the expiry flag in bit 16. All other bits read as 0. A write changes only bits 2:0.
- R3: A read of status/control returns the expiry flag as it stood before the read, then clears the flag. An expiry in the same cycle as the read leaves the flag set.
- R4: The reload register keeps bits 23:0 of a written word. Bits 31:24 read as 0.
- R5: While enabled and not halted, the count drops by one on each active tick of the selected source. While run-enable is 0, the count holds.
- R6: A decrement that reaches zero sets the expiry flag. If interrupt-enable is set, it also drives irq_o high for exactly one cycle, in the cycle after that decrement. The next active tick loads the reload value.
- R7: A write of any data to the current-count offset sets the count to 0 and clears the expiry flag. It raises no interrupt, even when an expiry would have happened in that cycle. Counting then continues, and the next active tick loads the reload value.
- R8: An expiry while the reload value is 0 halts counting but leaves run-enable reading 1. Only a write that sets run-enable when it was 0 resumes counting.
- R9: When has_ref_i is 0, source-select reads 1 after reset and after every write to status/control.
- R10: With has_ref_i at 0, calibration reads 0x8000_0000. Otherwise it reads the 10 ms tick count minus one in bits 23:0 and the inexact flag in bit 30.
- R11: An access with req_priv_i low gets rsp_err_o high and read data 0, and it changes no state, including the expiry flag.
- R12: Reset clears run-enable, interrupt-enable, the expiry flag, the count and the reload value. Reset sets source-select to the inverse of has_ref_i.
- R13: Every accepted request gets rsp_valid_o high in the following cycle, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the fast count source |
| rst | input | 1 | Synchronous reset, active high |
| has_ref_i | input | 1 | Configuration: a reference tick source exists |
| ref_tick_i | input | 1 | Single-cycle reference tick enable |
| req_valid_i | input | 1 | Register request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_priv_i | input | 1 | 1 = privileged access, 0 = refused |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response to the previous cycle's request |
| rsp_err_o | output | 1 | Response carries an access error |
| rsp_rdata_o | output | 32 | Read data of the response |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |

## Verification
The assertions assume that has_ref_i is static outside reset and changes only while rst is high. They also assume that the reference tick is an ordinary single-clock enable sampled at the block's clock edge. The bench changes has_ref_i only inside a reset window and drives ref_tick_i from the falling edge, with a random pattern that stays synchronous. Random reload values, wait lengths and interrupt-enable settings exercise count wrap and expiry counting. Directed sequences place a current-count write on the exact expiry tick and move the reload value to zero in the middle of a count.

// File: rtl/ptick_pkg.sv
package ptick_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned RUN_BIT   = 0;
    localparam int unsigned IRQ_BIT   = 1;
    localparam int unsigned SRC_BIT   = 2;
    localparam int unsigned FLAG_BIT  = 16;
    localparam int unsigned NOREF_BIT = 31;
    localparam int unsigned SKEW_BIT  = 30;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_RELOAD,
        SEL_CURRENT,
        SEL_CALIB,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic src_fast;
        logic irq_en;
        logic run_en;
    } ctrl_bits_t;

    typedef struct packed {
        logic wr_status;
        logic wr_reload;
        logic wr_current;
        logic rd_status;
    } bus_strobe_t;

    function automatic reg_sel_e decode_word(input logic aligned, input int unsigned idx);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (aligned) begin
            case (idx)
                0:       sel = SEL_STATUS;
                1:       sel = SEL_RELOAD;
                2:       sel = SEL_CURRENT;
                3:       sel = SEL_CALIB;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input ctrl_bits_t c, input logic flag);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RUN_BIT]  = c.run_en;
        w[IRQ_BIT]  = c.irq_en;
        w[SRC_BIT]  = c.src_fast;
        w[FLAG_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/ptick_bus.sv
module ptick_bus
    import ptick_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_priv_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [WORD_W-1:0] status_word_i,
    input  logic [WORD_W-1:0] reload_word_i,
    input  logic [WORD_W-1:0] current_word_i,
    input  logic [WORD_W-1:0] calib_word_i,
    output bus_strobe_t       strobe_o,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [WORD_W-1:0] rsp_rdata_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic              granted;
    reg_sel_e          sel;
    logic [WORD_W-1:0] rd_mux;
    logic [IDX_W-1:0]  word_idx;

    assign word_idx = req_addr_i[ADDR_W-1:2];
    assign granted  = req_valid_i & req_priv_i;
    assign sel      = decode_word(req_addr_i[1:0] == 2'b00, int'(word_idx));

    always_comb begin
        strobe_o            = '0;
        strobe_o.wr_status  = granted &  req_write_i & (sel == SEL_STATUS);
        strobe_o.wr_reload  = granted &  req_write_i & (sel == SEL_RELOAD);
        strobe_o.wr_current = granted &  req_write_i & (sel == SEL_CURRENT);
        strobe_o.rd_status  = granted & ~req_write_i & (sel == SEL_STATUS);
    end

    always_comb begin
        case (sel)
            SEL_STATUS:  rd_mux = status_word_i;
            SEL_RELOAD:  rd_mux = reload_word_i;
            SEL_CURRENT: rd_mux = current_word_i;
            SEL_CALIB:   rd_mux = calib_word_i;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_err_o   <= req_valid_i & ~req_priv_i;
            rsp_rdata_o <= (granted & ~req_write_i) ? rd_mux : '0;
        end
    end

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

    // R11
    unpriv_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_priv_i) |=> (rsp_err_o && rsp_rdata_o == '0));

    // R13
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);

endmodule

// File: rtl/ptick_count.sv
module ptick_count #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             wr_reload_i,
    input  logic             wr_current_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    logic             step;

    assign step     = run_i & tick_i & ~wr_current_i;
    assign expire_o = step & (count_q == CNT_W'(1));
    assign count_o  = count_q;
    assign reload_o = reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            if (wr_reload_i) begin
                reload_q <= wdata_i;
            end
            if (wr_current_i) begin
                count_q <= '0;
            end else if (step) begin
                count_q <= (count_q == '0) ? reload_q : count_q - CNT_W'(1);
            end
        end
    end

    // R7
    current_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_current_i |=> (count_q == '0));

    // R5
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !wr_current_i) |=> $stable(count_q));

    // R6
    reload_after_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_i && !wr_current_i && count_q == '0) |=> (count_q == $past(reload_q)));

endmodule

// File: rtl/ptick_ctrl.sv
module ptick_ctrl
    import ptick_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       has_ref_i,
    input  logic       wr_status_i,
    input  logic       rd_status_i,
    input  logic       wr_current_i,
    input  logic [2:0] wbits_i,
    input  logic       expire_i,
    input  logic       reload_zero_i,
    output ctrl_bits_t ctrl_o,
    output logic       flag_o,
    output logic       run_o,
    output logic       irq_o
);

    ctrl_bits_t ctrl_q;
    ctrl_bits_t ctrl_wr;
    logic       flag_q;
    logic       halt_q;
    logic       irq_q;
    logic       rearm;

    always_comb begin
        ctrl_wr.src_fast = wbits_i[SRC_BIT] | ~has_ref_i;
        ctrl_wr.irq_en   = wbits_i[IRQ_BIT];
        ctrl_wr.run_en   = wbits_i[RUN_BIT];
    end

    assign rearm = wr_status_i & ctrl_wr.run_en & ~ctrl_q.run_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.src_fast <= ~has_ref_i;
            ctrl_q.irq_en   <= 1'b0;
            ctrl_q.run_en   <= 1'b0;
            flag_q          <= 1'b0;
            halt_q          <= 1'b0;
            irq_q           <= 1'b0;
        end else begin
            if (wr_status_i) begin
                ctrl_q <= ctrl_wr;
            end
            flag_q <= expire_i | (flag_q & ~rd_status_i & ~wr_current_i);
            if (expire_i && reload_zero_i) begin
                halt_q <= 1'b1;
            end else if (rearm) begin
                halt_q <= 1'b0;
            end
            irq_q <= expire_i & ctrl_q.irq_en;
        end
    end

    assign ctrl_o = ctrl_q;
    assign flag_o = flag_q;
    assign run_o  = ctrl_q.run_en & ~halt_q;
    assign irq_o  = irq_q;

    // R9
    ref_absent_forces_fast_chk: assert property (@(posedge clk) disable iff (rst)
        !has_ref_i |-> ctrl_q.src_fast);

    // R3
    read_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_status_i && !expire_i) |=> !flag_q);

    // R6
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R6
    irq_implies_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> flag_q);

    // R7
    clear_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        wr_current_i |=> !irq_q);

    // R8
    halt_keeps_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_i && reload_zero_i && !wr_status_i) |=> (ctrl_q.run_en && !run_o));

endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
    import ptick_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned CAL_TENMS = 99999,
    parameter bit          CAL_SKEW  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              has_ref_i,
    input  logic              ref_tick_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_priv_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [31:0]       req_wdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [31:0]       rsp_rdata_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0] CAL_FIELD = CNT_W'(CAL_TENMS);

    bus_strobe_t       strobe;
    ctrl_bits_t        ctrl;
    logic              flag;
    logic              run;
    logic              tick;
    logic              expire;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  reload;
    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] calib_word;

    assign tick        = ctrl.src_fast | ref_tick_i;
    assign status_word = pack_status(ctrl, flag);

    always_comb begin
        calib_word = '0;
        if (has_ref_i) begin
            calib_word[CNT_W-1:0] = CAL_FIELD;
            calib_word[SKEW_BIT]  = CAL_SKEW;
        end else begin
            calib_word[NOREF_BIT] = 1'b1;
        end
    end

    ptick_bus #(
        .ADDR_W(ADDR_W)
    ) u_bus (
        .clk           (clk),
        .rst           (rst),
        .req_valid_i   (req_valid_i),
        .req_write_i   (req_write_i),
        .req_priv_i    (req_priv_i),
        .req_addr_i    (req_addr_i),
        .status_word_i (status_word),
        .reload_word_i (WORD_W'(reload)),
        .current_word_i(WORD_W'(count)),
        .calib_word_i  (calib_word),
        .strobe_o      (strobe),
        .rsp_valid_o   (rsp_valid_o),
        .rsp_err_o     (rsp_err_o),
        .rsp_rdata_o   (rsp_rdata_o)
    );

    ptick_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .has_ref_i    (has_ref_i),
        .wr_status_i  (strobe.wr_status),
        .rd_status_i  (strobe.rd_status),
        .wr_current_i (strobe.wr_current),
        .wbits_i      (req_wdata_i[2:0]),
        .expire_i     (expire),
        .reload_zero_i(reload == '0),
        .ctrl_o       (ctrl),
        .flag_o       (flag),
        .run_o        (run),
        .irq_o        (irq_o)
    );

    ptick_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run),
        .tick_i      (tick),
        .wr_reload_i (strobe.wr_reload),
        .wr_current_i(strobe.wr_current),
        .wdata_i     (req_wdata_i[CNT_W-1:0]),
        .count_o     (count),
        .reload_o    (reload),
        .expire_o    (expire)
    );

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq_o && !flag && count == '0 && reload == '0));

endmodule

// File: tb/periodic_tick_timer_tb.sv
module periodic_tick_timer_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned TB_TENMS   = 12345;
    localparam bit          TB_SKEW    = 1'b1;
    localparam logic [7:0]  A_STAT = 8'h00, A_RLD = 8'h04, A_CUR = 8'h08, A_CAL = 8'h0C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              has_ref_i = 1'b1;
    logic              ref_tick_i = 1'b0;
    logic              req_valid_i = 1'b0;
    logic              req_write_i = 1'b0;
    logic              req_priv_i = 1'b1;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [31:0]       req_wdata_i = '0;
    logic              rsp_valid_o;
    logic              rsp_err_o;
    logic [31:0]       rsp_rdata_o;
    logic              irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_seen = 0;
    int ref_cnt  = 0;
    bit ref_count_en = 1'b0;
    bit ref_rand_en  = 1'b0;

    periodic_tick_timer #(
        .ADDR_W(ADDR_W), .CNT_W(24), .CAL_TENMS(TB_TENMS), .CAL_SKEW(TB_SKEW)
    ) u_dut (
        .clk(clk), .rst(rst), .has_ref_i(has_ref_i), .ref_tick_i(ref_tick_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_priv_i(req_priv_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (irq_o) irq_seen++;
        ref_tick_i <= ref_rand_en ? (($urandom % 3) == 0) : 1'b0;
    end

    always @(posedge clk) begin
        if (ref_count_en && ref_tick_i) ref_cnt++;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                          input bit priv, output logic [31:0] rd, output logic err);
        req_valid_i = 1'b1;
        req_write_i = wr;
        req_addr_i  = a;
        req_wdata_i = d;
        req_priv_i  = priv;
        @(negedge clk);
        check("R13 rsp_valid", {31'b0, rsp_valid_o}, 32'd1);
        rd  = rsp_rdata_o;
        err = rsp_err_o;
        req_valid_i = 1'b0;
        req_priv_i  = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r; logic e;
        access(1'b1, a, d, 1'b1, r, e);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] r; logic e;
        access(1'b0, a, '0, 1'b1, r, e);
        check(req, r, exp);
    endtask

    function automatic int unsigned exp_count(input int unsigned rl, input int unsigned t);
        if (t == 0) return 0;
        return rl - ((t - 1) % (rl + 1));
    endfunction

    function automatic int unsigned exp_irqs(input int unsigned rl, input int unsigned t);
        return t / (rl + 1);
    endfunction

    task automatic do_reset(input bit ref_present);
        rst = 1'b1;
        has_ref_i = ref_present;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        logic        e;
        int unsigned seed;
        seed = $urandom(32'd7001);

        @(negedge clk);
        do_reset(1'b1);

        // R12 reset state
        rd_exp(A_STAT, 32'h0, "R12 status after reset");
        rd_exp(A_RLD,  32'h0, "R12 reload after reset");
        rd_exp(A_CUR,  32'h0, "R12 count after reset");
        check("R12 irq after reset", {31'b0, irq_o}, 32'd0);
        @(negedge clk);
        check("R13 idle rsp_valid", {31'b0, rsp_valid_o}, 32'd0);

        // R10 calibration with reference present
        rd_exp(A_CAL, 32'h4000_0000 | TB_TENMS, "R10 calibration");

        // R4 reload width
        wr(A_RLD, 32'hFFFF_FFFF);
        rd_exp(A_RLD, 32'h00FF_FFFF, "R4 reload upper bits");

        // R2 only bits 2:0 written
        wr(A_STAT, 32'hFFFF_FFF8);
        rd_exp(A_STAT, 32'h0, "R2 upper write bits ignored");
        wr(A_STAT, 32'hFFFF_FFFE);
        rd_exp(A_STAT, 32'h6, "R2 control bit layout");
        wr(A_STAT, 32'h0);

        // R1 undefined and misaligned offsets
        rd_exp(8'h10, 32'h0, "R1 undefined read");
        wr(8'h14, 32'hFFFF_FFFF);
        rd_exp(A_STAT, 32'h0, "R1 undefined write no status change");
        rd_exp(A_RLD, 32'h00FF_FFFF, "R1 undefined write no reload change");
        rd_exp(8'h05, 32'h0, "R1 misaligned read");

        // R5 R6 random fast-source runs
        for (int it = 0; it < 20; it++) begin
            int unsigned rl, w, ie, t;
            rl = 1 + ($urandom % 40);
            w  = $urandom % 90;
            ie = $urandom % 2;
            wr(A_CUR, $urandom);
            wr(A_RLD, rl);
            irq_seen = 0;
            wr(A_STAT, 32'h5 | (ie << 1));
            repeat (w) @(negedge clk);
            wr(A_STAT, 32'h4 | (ie << 1));
            t = w + 1;
            repeat (2) @(negedge clk);
            rd_exp(A_CUR, exp_count(rl, t), "R5 fast-source count");
            rd_exp(A_STAT, ((t >= rl + 1) ? 32'h1_0000 : 32'h0) | 32'h4 | (ie << 1),
                   "R6 expiry flag");
            check("R6 irq pulses", irq_seen, ie ? exp_irqs(rl, t) : 0);
            repeat (4) @(negedge clk);
            rd_exp(A_CUR, exp_count(rl, t), "R5 count holds when disabled");
        end

        // R5 R6 random reference-tick runs
        ref_rand_en = 1'b1;
        for (int it = 0; it < 10; it++) begin
            int unsigned rl, w, ie, t;
            rl = 1 + ($urandom % 12);
            w  = $urandom % 60;
            ie = $urandom % 2;
            wr(A_CUR, 32'h0);
            wr(A_RLD, rl);
            irq_seen = 0;
            ref_cnt  = 0;
            wr(A_STAT, 32'h1 | (ie << 1));
            ref_count_en = 1'b1;
            repeat (w) @(negedge clk);
            wr(A_STAT, (ie << 1));
            ref_count_en = 1'b0;
            t = ref_cnt;
            repeat (2) @(negedge clk);
            rd_exp(A_CUR, exp_count(rl, t), "R5 reference-tick count");
            rd_exp(A_STAT, ((t >= rl + 1) ? 32'h1_0000 : 32'h0) | (ie << 1),
                   "R6 reference expiry flag");
            check("R6 reference irq pulses", irq_seen, ie ? exp_irqs(rl, t) : 0);
        end
        ref_rand_en = 1'b0;

        // R7 clear on the exact expiry tick
        wr(A_CUR, 32'h0);
        wr(A_RLD, 32'd10);
        irq_seen = 0;
        wr(A_STAT, 32'h7);
        repeat (21) @(negedge clk);
        wr(A_CUR, 32'hDEAD_BEEF);
        rd_exp(A_STAT, 32'h7, "R7 clear wipes flag and beats expiry");
        wr(A_STAT, 32'h6);
        repeat (2) @(negedge clk);
        check("R7 no irq from clear", irq_seen, 1);
        rd_exp(A_CUR, 32'd9, "R7 reload after clear");

        // R8 zero reload halts
        wr(A_CUR, 32'h0);
        wr(A_RLD, 32'd5);
        wr(A_STAT, 32'h5);
        wr(A_RLD, 32'd0);
        repeat (20) @(negedge clk);
        rd_exp(A_STAT, 32'h1_0005, "R8 enable stays set after halt");
        wr(A_RLD, 32'd4);
        repeat (10) @(negedge clk);
        rd_exp(A_CUR, 32'd0, "R8 halted count stays zero");
        wr(A_STAT, 32'h4);
        wr(A_STAT, 32'h5);
        rd_exp(A_CUR, 32'd0, "R8 count before first tick after rearm");
        rd_exp(A_CUR, 32'd4, "R8 rearm loads reload");
        wr(A_STAT, 32'h4);

        // R11 R3 privilege and read-clear
        wr(A_STAT, 32'h0);
        wr(A_RLD, 32'd3);
        access(1'b1, A_RLD, 32'd9, 1'b0, r, e);
        check("R11 unpriv write error", {31'b0, e}, 32'd1);
        rd_exp(A_RLD, 32'd3, "R11 unpriv write ignored");
        access(1'b1, A_STAT, 32'h7, 1'b0, r, e);
        rd_exp(A_STAT, 32'h0, "R11 unpriv status write ignored");
        wr(A_CUR, 32'h0);
        wr(A_RLD, 32'd2);
        wr(A_STAT, 32'h5);
        repeat (5) @(negedge clk);
        wr(A_STAT, 32'h4);
        access(1'b0, A_STAT, 32'h0, 1'b0, r, e);
        check("R11 unpriv read error", {31'b0, e}, 32'd1);
        check("R11 unpriv read data zero", r, 32'h0);
        access(1'b1, A_CUR, 32'h0, 1'b0, r, e);
        rd_exp(A_STAT, 32'h1_0004, "R3 flag survives refused accesses");
        rd_exp(A_STAT, 32'h4, "R3 flag cleared by read");

        // R9 R10 R12 without reference source
        do_reset(1'b0);
        rd_exp(A_STAT, 32'h4, "R12 R9 reset select without reference");
        rd_exp(A_CAL, 32'h8000_0000, "R10 calibration without reference");
        wr(A_STAT, 32'h1);
        rd_exp(A_STAT, 32'h5, "R9 select forced on write");
        wr(A_STAT, 32'h0);
        rd_exp(A_STAT, 32'h4, "R9 select forced on clearing write");

        summary();
        $finish;
    end

endmodule